// File: doc/BRIEF.md
# Rotor Stall Watchdog with Protect Latch

This block watches a three-phase brushless motor for a stalled rotor. A slow timing oscillator, standing in for an external capacitor sawtooth, delivers ticks that advance a counter. Every change of any of the three Hall sensor levels, in either direction, returns the counter to zero. While the rotor turns, Hall edges arrive far more often than the counter can fill. When the rotor stops, the counter runs past its top value. That overflow raises a stall flag, and the flag sets a protect latch that keeps the bridge driver suspended.

All inputs are asynchronous to the system clock and are synchronized inside the block. Monitoring runs only while the run command is high. The protect latch stays set after the rotor moves again. Only a power-on reset, taking run low, or flipping the direction command releases it. The suspend sequencing that consumes the latch lies outside this block.

The latch sequencer has three named states. `ST_IDLE` means run is low and nothing is monitored. `ST_WATCH` means run is high and the counter is armed. `ST_TRIP` means a stall has been seen and the protect output is high. The transitions are as follows:

- idle-to-watch fires when run is high.
- watch-to-idle fires when run is low.
- watch-to-trip fires on a stall flag.
- trip-to-idle fires on a run fall.
- trip-to-watch fires on a direction change with run still high.

Top module: `rotor_stall_guard`

## Requirements
- R1: After power-on reset, with run low, both stall_detect and stall_protect read 0.
- R2: The counter (CNT_W bits) advances once for each rising edge of osc_tick. The tick that finds the counter at its all-ones value sets stall_detect. So stall_detect is set after exactly 2^CNT_W ticks without a clearing event, and stays 0 after fewer.
- R3: A rising or falling edge on any single bit of hall clears the counter and stall_detect, so the count restarts from zero.
- R4: Once set, stall_detect stays 1 as further ticks arrive. It clears only on a Hall edge, a direction change, or run going low.
- R5: stall_protect becomes 1 once stall_detect is set with run high. It stays 1 after a Hall edge has cleared stall_detect.
- R6: Changing dir while run is high clears stall_protect, and monitoring restarts from a zero count.
- R7: Taking run low clears stall_protect, stall_detect and the counter. Ticks that arrive while run is low have no effect.
- R8: Asserting power-on reset (rst_n low) clears a set stall_protect.
- R9: A change of dir clears the counter even when no stall is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_tick | input | 1 | Timing oscillator output, one count per rising edge |
| hall | input | 3 | Squared Hall sensor levels for the three phase pairs |
| run | input | 1 | Run command, high enables monitoring |
| dir | input | 1 | Direction command, any change clears the latch |
| stall_detect | output | 1 | Counter overflow flag |
| stall_protect | output | 1 | Latched stall protect, holds the driver suspended |

## Verification
The hardest situation to reach from the ports is the exact overflow boundary: the tick that takes the counter from all ones to overflow, compared with a Hall edge that arrives one tick earlier. The bench sets the counter width to three bits. It sweeps the tick count from zero past 2^CNT_W. It also splits a full window by a Hall edge at every position, on each of the three Hall bits in turn. In every case the bench compares the outcome with the 2^CNT_W threshold it computes itself. Release of the latch is then reached separately through a direction flip, a run fall and a power-on reset.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_TRIP  = 2'd2
    } rsg_state_e;

    localparam int unsigned IN_TICK = 0;
    localparam int unsigned IN_HALL = 1;
    localparam int unsigned N_HALL  = 3;
    localparam int unsigned IN_RUN  = IN_HALL + N_HALL;
    localparam int unsigned IN_DIR  = IN_RUN + 1;
    localparam int unsigned N_IN    = IN_DIR + 1;

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] level,
    output logic [W-1:0] prev
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];

    // previous stage must trail the output stage by exactly one cycle (R3)
    p_prev_trails_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev == $past(level));

endmodule

// File: rtl/rsg_tick_counter.sv
module rsg_tick_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_on,
    input  logic tick_rise,
    input  logic clr,
    output logic stall_det
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic             det_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            det_q   <= 1'b0;
        end else if (!run_on || clr) begin
            count_q <= '0;
            det_q   <= 1'b0;
        end else if (tick_rise) begin
            count_q <= count_q + 1'b1;
            if (count_q == CNT_MAX) det_q <= 1'b1;
        end
    end

    assign stall_det = det_q;

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0) && !det_q);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on |=> !det_q && (count_q == '0));

    p_set_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q) |-> (count_q == '0) && $past(tick_rise));

    p_detect_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        det_q && run_on && !clr |=> det_q);

endmodule

// File: rtl/rsg_latch_fsm.sv
module rsg_latch_fsm
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_on,
    input  logic run_fall,
    input  logic dir_change,
    input  logic stall_det,
    output logic stall_protect
);

    rsg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_on) state_d = ST_WATCH;
            ST_WATCH: begin
                if (!run_on)        state_d = ST_IDLE;
                else if (stall_det) state_d = ST_TRIP;
            end
            ST_TRIP: begin
                if (run_fall || !run_on) state_d = ST_IDLE;
                else if (dir_change)     state_d = ST_WATCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        stall_protect = (state_q == ST_TRIP);
    end

    p_trip_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH) && run_on && stall_det |=> state_q == ST_TRIP);

    p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIP) && run_on && !dir_change |=> state_q == ST_TRIP);

    p_dir_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIP) && run_on && dir_change |=> state_q == ST_WATCH);

    p_run_low_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on |=> state_q != ST_TRIP);

endmodule

// File: rtl/rotor_stall_guard.sv
module rotor_stall_guard
    import rsg_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [2:0] hall,
    input  logic       run,
    input  logic       dir,
    output logic       stall_detect,
    output logic       stall_protect
);

    logic [N_IN-1:0] raw_in, lvl, prv;
    logic            tick_rise, hall_change, dir_change, run_fall, run_on;
    logic            cnt_clr, det;

    assign raw_in = {dir, run, hall, osc_tick};

    rsg_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .level (lvl),
        .prev  (prv)
    );

    assign tick_rise   = lvl[IN_TICK] & ~prv[IN_TICK];
    assign hall_change = |(lvl[IN_HALL +: N_HALL] ^ prv[IN_HALL +: N_HALL]);
    assign dir_change  = lvl[IN_DIR] ^ prv[IN_DIR];
    assign run_on      = lvl[IN_RUN];
    assign run_fall    = prv[IN_RUN] & ~lvl[IN_RUN];
    assign cnt_clr     = hall_change | dir_change;

    rsg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_on    (run_on),
        .tick_rise (tick_rise),
        .clr       (cnt_clr),
        .stall_det (det)
    );

    rsg_latch_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_on        (run_on),
        .run_fall      (run_fall),
        .dir_change    (dir_change),
        .stall_det     (det),
        .stall_protect (stall_protect)
    );

    assign stall_detect = det;

    p_hall_edge_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hall_change |=> !stall_detect);

endmodule

// File: tb/tb_rotor_stall_guard.sv
module tb_rotor_stall_guard;

    localparam int unsigned CNT_W = 3;
    localparam int          LIMIT = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [2:0] hall = 3'b000;
    logic       run = 1'b0;
    logic       dir = 1'b0;
    logic       stall_detect, stall_protect;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rotor_stall_guard #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_tick      (osc_tick),
        .hall          (hall),
        .run           (run),
        .dir           (dir),
        .stall_detect  (stall_detect),
        .stall_protect (stall_protect)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual hung, expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1; wait_cyc(3);
            osc_tick = 1'b0; wait_cyc(3);
        end
        wait_cyc(6);
    endtask

    task automatic flip_hall(input int b);
        hall[b] = ~hall[b];
        wait_cyc(8);
    endtask

    task automatic flip_dir();
        dir = ~dir;
        wait_cyc(8);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        // R1 reset state
        check("R1 detect", stall_detect, 1'b0);
        check("R1 protect", stall_protect, 1'b0);
        ticks(LIMIT + 2);
        check("R7 ticks with run low", stall_detect, 1'b0);

        run = 1'b1;
        wait_cyc(8);

        // R2 sweep of tick count around the overflow
        for (int n = 0; n <= LIMIT + 3; n++) begin
            flip_hall(n % 3);
            ticks(n);
            check("R2 detect vs count", stall_detect, n >= LIMIT);
            check("R5 protect vs count", stall_protect, n >= LIMIT);
            if (n >= LIMIT) begin
                check("R4 detect sticky", stall_detect, 1'b1);
                flip_hall((n + 1) % 3);
                check("R3 hall edge clears detect", stall_detect, 1'b0);
                check("R5 protect held", stall_protect, 1'b1);
                flip_dir();
                check("R6 dir releases protect", stall_protect, 1'b0);
                check("R6 detect after dir", stall_detect, 1'b0);
            end
        end

        // R3 a hall edge at every split point, each hall bit
        for (int b = 0; b < 3; b++) begin
            for (int k = 1; k < LIMIT; k++) begin
                flip_hall(b);
                ticks(k);
                flip_hall(b);
                ticks(LIMIT - 1);
                check("R3 split window", stall_detect, 1'b0);
                check("R3 split window protect", stall_protect, 1'b0);
            end
        end

        // R9 dir change restarts the count without a latch
        flip_hall(0);
        ticks(LIMIT - 3);
        flip_dir();
        ticks(LIMIT - 1);
        check("R9 dir clears count", stall_detect, 1'b0);
        ticks(1);
        check("R9 full window after dir", stall_detect, 1'b1);
        check("R5 protect after trip", stall_protect, 1'b1);

        // R7 run low releases all and ignores ticks
        run = 1'b0;
        wait_cyc(8);
        check("R7 protect after run low", stall_protect, 1'b0);
        check("R7 detect after run low", stall_detect, 1'b0);
        ticks(2 * LIMIT);
        check("R7 ticks ignored", stall_detect, 1'b0);
        run = 1'b1;
        wait_cyc(8);
        check("R7 protect after rerun", stall_protect, 1'b0);
        ticks(LIMIT - 1);
        check("R7 count restarted", stall_detect, 1'b0);
        ticks(1);
        check("R2 trip again", stall_protect, 1'b1);

        // R8 power-on reset releases the latch
        rst_n = 1'b0;
        wait_cyc(3);
        check("R8 protect in reset", stall_protect, 1'b0);
        rst_n = 1'b1;
        wait_cyc(8);
        check("R8 protect after reset", stall_protect, 1'b0);
        check("R8 detect after reset", stall_detect, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule